// File: doc/BRIEF.md
# Accumulator Processor Control Sequencer

This block is a small single-accumulator processor. Each instruction is carried out as a fixed chain of register transfers between a program counter, a memory address register, a memory data register, an instruction register, the accumulator and an output register. Only one transfer happens per state. A Moore-style control state machine first walks every instruction through a four-state fetch and a decode state. It then walks it through an execute chain chosen by the opcode. Program and data share a 100-word synchronous memory inside the block, and the testbench fills that memory while reset is held.

The block exchanges words with its environment through a ready/valid input port, an output register qualified by a one-cycle strobe, and two status lines, stopped and fault. The carry and overflow flags of the last add or subtract are brought out as well.

Instruction word (12 bits): opcode in bits 11:8, address in bits 6:0, and bit 7 ignored. Opcodes are 0 halt, 1 add, 2 subtract, 3 store, 5 load, 6 jump, 7 jump-if-zero and 8 jump-if-positive. Opcode 9 is the I/O group: address 1 means input and address 2 means output.

States, in order of use:
- Fetch: FETCH_MAR (MAR←PC), FETCH_RD (memory read issued), FETCH_MDR (MDR←memory), FETCH_IR (IR←MDR).
- DECODE: picks the execute path.
- Operand path: OPND_MAR (MAR←address field). Add, subtract and load then go OPND_RD → OPND_MDR → ALU (accumulator update). Store instead goes ST_MDR (MDR←accumulator) → ST_WR (memory←MDR).
- IN_WAIT: accumulator←input word, once it is valid.
- OUT_XFER: output register←accumulator, and the strobe is raised.
- JUMP: PC←address field.
- PC_INC: PC+1, wrapping from 99 to 0.
- STOP and FAULT: terminal states.

Transitions:
- FETCH_MAR→FETCH_RD→FETCH_MDR→FETCH_IR→DECODE.
- DECODE goes to OPND_MAR for add, subtract, load and store. It goes to JUMP for a jump, or for a conditional jump whose condition holds. It goes to PC_INC for a conditional jump whose condition fails. It goes to IN_WAIT or OUT_XFER for I/O, to STOP for halt, and to FAULT for anything illegal.
- OPND_MAR→ST_MDR for store, and OPND_MAR→OPND_RD otherwise.
- OPND_RD→OPND_MDR→ALU→PC_INC.
- ST_MDR→ST_WR→PC_INC.
- IN_WAIT stays put until the input is valid, then goes to PC_INC.
- OUT_XFER→PC_INC.
- JUMP→FETCH_MAR, and PC_INC→FETCH_MAR.
- STOP and FAULT hold until reset.

Top module: `accum_cpu`

## Requirements
- R1: While and after reset, the PC is 0, the accumulator is 0, the carry and overflow flags are 0, and the state is FETCH_MAR. So stopped, fault, in_ready and out_strobe are low, out_data is 0, and the first instruction comes from address 0.
- R2: Each instruction is fetched from the word at the PC. The opcode is bits 11:8, the address field is bits 6:0, and bit 7 has no effect.
- R3: Add (1) sets ACC←ACC+M, subtract (2) sets ACC←ACC−M, and load (5) sets ACC←M. M is the memory word at the address field, and results are modulo 2^12.
- R4: Add and subtract set carry to the carry out of bit 11 (for subtract, carry=1 when ACC<M unsigned). They set overflow to two's-complement overflow. All other instructions leave both flags unchanged.
- R5: Store (3) writes the accumulator into the memory word at the address field. A later load of that word returns it.
- R6: Input (0x901) raises in_ready and waits in that state until in_valid is high. It then copies in_data into the accumulator and consumes exactly one word. in_ready is low in every other state.
- R7: Output (0x902) places the accumulator on out_data and raises out_strobe for exactly one cycle. out_data changes only together with a strobe.
- R8: Jump (6) loads the address field into the PC with no increment.
- R9: Jump-if-zero (7) is taken when ACC==0. Jump-if-positive (8) is taken when ACC bit 11 is 0. When the condition fails, the PC increments instead.
- R10: Halt (0) enters STOP after its fetch. stopped is then high and stays high, and no further input is requested and no further output is produced.
- R11: These cases enter FAULT, which raises both fault and stopped: opcodes 4 and 10–15, opcode 9 with an address other than 1 or 2, and an address field of 100–127 on any memory or jump instruction.
- R12: The PC counts from 99 back to 0 and never holds a value above 99.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 12 | Word offered to the input instruction |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | The input instruction is waiting for a word |
| out_data | output | 12 | Output register |
| out_strobe | output | 1 | One-cycle pulse when out_data is newly written |
| stopped | output | 1 | Processor has stopped (halt or fault) |
| fault | output | 1 | Stopped on an illegal instruction |
| flag_carry | output | 1 | Carry/borrow of the last add or subtract |
| flag_ovf | output | 1 | Signed overflow of the last add or subtract |

## Verification
Directed programs come first. One drives jump, store and load through the wrap from address 99 to 0, and reaches its output only if the stored word and the wrapped PC are both right. Another runs conditional jumps against zero, small positive, negative and most-positive inputs, which separates taken branches from fall-through branches. A third places each kind of illegal word after one good output, which shows that faults stop execution at the right point. Random programs then chain input, two arithmetic operations on random operands, a load and outputs, with random input stalls. Directed corner values (0x7FF+1, 0xFFF+1, 0−1, 0x800−1) tell carry apart from overflow, and the trailing load shows that the flags survive a non-arithmetic instruction.

// File: rtl/accum_cpu_pkg.sv
package accum_cpu_pkg;

    localparam int OP_W = 4;

    // opcode values
    localparam logic [OP_W-1:0] OP_HALT  = 4'd0;
    localparam logic [OP_W-1:0] OP_ADD   = 4'd1;
    localparam logic [OP_W-1:0] OP_SUB   = 4'd2;
    localparam logic [OP_W-1:0] OP_STORE = 4'd3;
    localparam logic [OP_W-1:0] OP_LOAD  = 4'd5;
    localparam logic [OP_W-1:0] OP_JUMP  = 4'd6;
    localparam logic [OP_W-1:0] OP_JZERO = 4'd7;
    localparam logic [OP_W-1:0] OP_JPOS  = 4'd8;
    localparam logic [OP_W-1:0] OP_IO    = 4'd9;

    localparam int IO_IN  = 1;
    localparam int IO_OUT = 2;

    typedef enum logic [4:0] {
        S_FETCH_MAR, S_FETCH_RD, S_FETCH_MDR, S_FETCH_IR, S_DECODE,
        S_OPND_MAR, S_OPND_RD, S_OPND_MDR, S_ALU,
        S_ST_MDR, S_ST_WR, S_IN_WAIT, S_OUT_XFER,
        S_JUMP, S_PC_INC, S_STOP, S_FAULT
    } state_e;

    typedef enum logic [2:0] {
        ACC_HOLD, ACC_LOAD, ACC_ADD, ACC_SUB, ACC_IN
    } acc_sel_e;

    typedef struct packed {
        logic     mar_from_pc;
        logic     mar_from_ir;
        logic     mem_rd;
        logic     mdr_from_mem;
        logic     mdr_from_acc;
        logic     mem_wr;
        logic     ir_load;
        acc_sel_e acc_sel;
        logic     pc_inc;
        logic     pc_jump;
        logic     out_load;
    } ctrl_t;

endpackage

// File: rtl/accum_mem.sv
module accum_mem #(
    parameter int DATA_W = 12,
    parameter int ADDR_W = 7,
    parameter int DEPTH  = 100
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // one cycle of read latency; the address is always below DEPTH
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wdata;
        end
        if (rd_en) begin
            rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/accum_alu.sv
module accum_alu #(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              do_sub,
    output logic [DATA_W-1:0] result,
    output logic              carry,
    output logic              ovf
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] wide;

    always_comb begin
        if (do_sub) begin
            wide = {1'b0, a} - {1'b0, b};
        end else begin
            wide = {1'b0, a} + {1'b0, b};
        end
        result = wide[DATA_W-1:0];
        carry  = wide[DATA_W];
        if (do_sub) begin
            ovf = (a[MSB] != b[MSB]) && (result[MSB] != a[MSB]);
        end else begin
            ovf = (a[MSB] == b[MSB]) && (result[MSB] != a[MSB]);
        end
    end

endmodule

// File: rtl/accum_fsm.sv
module accum_fsm
    import accum_cpu_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DEPTH  = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   opcode,
    input  logic [ADDR_W-1:0] addr_field,
    input  logic              acc_zero,
    input  logic              acc_neg,
    input  logic              in_valid,
    output state_e            state,
    output ctrl_t             ctrl
);

    state_e state_d;
    logic   addr_ok;

    assign addr_ok = (int'(addr_field) < DEPTH);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_FETCH_MAR;
        end else begin
            state <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state;
        unique case (state)
            S_FETCH_MAR: state_d = S_FETCH_RD;
            S_FETCH_RD:  state_d = S_FETCH_MDR;
            S_FETCH_MDR: state_d = S_FETCH_IR;
            S_FETCH_IR:  state_d = S_DECODE;
            S_DECODE: begin
                case (opcode)
                    OP_ADD, OP_SUB, OP_LOAD, OP_STORE:
                        state_d = addr_ok ? S_OPND_MAR : S_FAULT;
                    OP_JUMP:
                        state_d = addr_ok ? S_JUMP : S_FAULT;
                    OP_JZERO:
                        state_d = !addr_ok ? S_FAULT : (acc_zero ? S_JUMP : S_PC_INC);
                    OP_JPOS:
                        state_d = !addr_ok ? S_FAULT : (!acc_neg ? S_JUMP : S_PC_INC);
                    OP_IO: begin
                        if (int'(addr_field) == IO_IN) begin
                            state_d = S_IN_WAIT;
                        end else if (int'(addr_field) == IO_OUT) begin
                            state_d = S_OUT_XFER;
                        end else begin
                            state_d = S_FAULT;
                        end
                    end
                    OP_HALT: state_d = S_STOP;
                    default: state_d = S_FAULT;
                endcase
            end
            S_OPND_MAR:  state_d = (opcode == OP_STORE) ? S_ST_MDR : S_OPND_RD;
            S_OPND_RD:   state_d = S_OPND_MDR;
            S_OPND_MDR:  state_d = S_ALU;
            S_ALU:       state_d = S_PC_INC;
            S_ST_MDR:    state_d = S_ST_WR;
            S_ST_WR:     state_d = S_PC_INC;
            S_IN_WAIT:   state_d = in_valid ? S_PC_INC : S_IN_WAIT;
            S_OUT_XFER:  state_d = S_PC_INC;
            S_JUMP:      state_d = S_FETCH_MAR;
            S_PC_INC:    state_d = S_FETCH_MAR;
            S_STOP:      state_d = S_STOP;
            S_FAULT:     state_d = S_FAULT;
            default:     state_d = S_FAULT;
        endcase
    end

    // control outputs, one transfer per state
    always_comb begin
        ctrl         = '0;
        ctrl.acc_sel = ACC_HOLD;
        unique case (state)
            S_FETCH_MAR: ctrl.mar_from_pc  = 1'b1;
            S_FETCH_RD:  ctrl.mem_rd       = 1'b1;
            S_FETCH_MDR: ctrl.mdr_from_mem = 1'b1;
            S_FETCH_IR:  ctrl.ir_load      = 1'b1;
            S_OPND_MAR:  ctrl.mar_from_ir  = 1'b1;
            S_OPND_RD:   ctrl.mem_rd       = 1'b1;
            S_OPND_MDR:  ctrl.mdr_from_mem = 1'b1;
            S_ALU: begin
                if (opcode == OP_ADD) begin
                    ctrl.acc_sel = ACC_ADD;
                end else if (opcode == OP_SUB) begin
                    ctrl.acc_sel = ACC_SUB;
                end else begin
                    ctrl.acc_sel = ACC_LOAD;
                end
            end
            S_ST_MDR:    ctrl.mdr_from_acc = 1'b1;
            S_ST_WR:     ctrl.mem_wr       = 1'b1;
            S_IN_WAIT:   ctrl.acc_sel      = in_valid ? ACC_IN : ACC_HOLD;
            S_OUT_XFER:  ctrl.out_load     = 1'b1;
            S_JUMP:      ctrl.pc_jump      = 1'b1;
            S_PC_INC:    ctrl.pc_inc       = 1'b1;
            default:     ctrl.acc_sel      = ACC_HOLD;
        endcase
    end

endmodule

// File: rtl/accum_cpu.sv
module accum_cpu
    import accum_cpu_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int ADDR_W = 7,
    parameter int DEPTH  = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_strobe,
    output logic              stopped,
    output logic              fault,
    output logic              flag_carry,
    output logic              flag_ovf
);

    localparam int GAP_W = DATA_W - OP_W - ADDR_W;
    localparam logic [ADDR_W-1:0] PC_LAST = ADDR_W'(DEPTH - 1);

    state_e            state;
    ctrl_t             ctrl;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] mar_q;
    logic [DATA_W-1:0] mdr_q;
    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] mem_q;
    logic [DATA_W-1:0] alu_res;
    logic              alu_carry;
    logic              alu_ovf;
    logic [OP_W-1:0]   opcode;
    logic [ADDR_W-1:0] addr_field;

    assign opcode     = ir_q[DATA_W-1 -: OP_W];
    assign addr_field = ir_q[ADDR_W-1:0];

    generate
        if (GAP_W > 0) begin : g_gap
            logic unused_gap;
            assign unused_gap = ^ir_q[ADDR_W +: GAP_W];
        end
    endgenerate

    accum_fsm #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .opcode     (opcode),
        .addr_field (addr_field),
        .acc_zero   (acc_q == '0),
        .acc_neg    (acc_q[DATA_W-1]),
        .in_valid   (in_valid),
        .state      (state),
        .ctrl       (ctrl)
    );

    accum_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .rd_en (ctrl.mem_rd),
        .wr_en (ctrl.mem_wr),
        .addr  (mar_q),
        .wdata (mdr_q),
        .rdata (mem_q)
    );

    accum_alu #(.DATA_W(DATA_W)) u_alu (
        .a      (acc_q),
        .b      (mdr_q),
        .do_sub (ctrl.acc_sel == ACC_SUB),
        .result (alu_res),
        .carry  (alu_carry),
        .ovf    (alu_ovf)
    );

    // register-transfer datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q       <= '0;
            mar_q      <= '0;
            mdr_q      <= '0;
            ir_q       <= '0;
            acc_q      <= '0;
            flag_carry <= 1'b0;
            flag_ovf   <= 1'b0;
            out_data   <= '0;
            out_strobe <= 1'b0;
        end else begin
            if (ctrl.mar_from_pc) mar_q <= pc_q;
            if (ctrl.mar_from_ir) mar_q <= addr_field;
            if (ctrl.mdr_from_mem) mdr_q <= mem_q;
            if (ctrl.mdr_from_acc) mdr_q <= acc_q;
            if (ctrl.ir_load) ir_q <= mdr_q;
            if (ctrl.pc_inc) pc_q <= (pc_q == PC_LAST) ? '0 : pc_q + 1'b1;
            if (ctrl.pc_jump) pc_q <= addr_field;
            unique case (ctrl.acc_sel)
                ACC_LOAD: acc_q <= mdr_q;
                ACC_IN:   acc_q <= in_data;
                ACC_ADD, ACC_SUB: begin
                    acc_q      <= alu_res;
                    flag_carry <= alu_carry;
                    flag_ovf   <= alu_ovf;
                end
                default: acc_q <= acc_q;
            endcase
            out_strobe <= ctrl.out_load;
            if (ctrl.out_load) out_data <= acc_q;
        end
    end

    assign in_ready = (state == S_IN_WAIT);
    assign stopped  = (state == S_STOP) || (state == S_FAULT);
    assign fault    = (state == S_FAULT);

endmodule

// File: rtl/accum_cpu_chk.sv
module accum_cpu_chk #(
    parameter int DATA_W = 12,
    parameter int ADDR_W = 7,
    parameter int DEPTH  = 100
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] pc,
    input logic              in_ready,
    input logic              in_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_strobe,
    input logic              stopped,
    input logic              fault,
    input logic              flag_carry,
    input logic              flag_ovf
);

    p_pc_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pc) < DEPTH);

    p_strobe_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_strobe |=> !out_strobe);

    p_out_with_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_strobe |=> (out_strobe || $stable(out_data)));

    p_wait_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> in_ready);

    p_take_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid) |=> !in_ready);

    p_stop_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |=> (stopped && !in_ready && !out_strobe));

    p_flags_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |=> $stable({flag_carry, flag_ovf}));

    p_fault_stops_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> stopped);

endmodule

bind accum_cpu accum_cpu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc         (pc_q),
    .in_ready   (in_ready),
    .in_valid   (in_valid),
    .out_data   (out_data),
    .out_strobe (out_strobe),
    .stopped    (stopped),
    .fault      (fault),
    .flag_carry (flag_carry),
    .flag_ovf   (flag_ovf)
);

// File: tb/accum_cpu_bench.sv
module accum_cpu_bench;

    localparam int DW    = 12;
    localparam int DEPTH = 100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] out_data;
    logic          out_strobe;
    logic          stopped;
    logic          fault;
    logic          flag_carry;
    logic          flag_ovf;

    int n_vec  = 0;
    int n_fail = 0;

    logic [DW-1:0] prog    [DEPTH];
    logic [DW-1:0] ins     [8];
    logic [DW-1:0] exp_out [8];

    always #2 clk = ~clk;

    accum_cpu u_accum_cpu (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .out_data   (out_data),
        .out_strobe (out_strobe),
        .stopped    (stopped),
        .fault      (fault),
        .flag_carry (flag_carry),
        .flag_ovf   (flag_ovf)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    // reference arithmetic: {carry, ovf, result}
    function automatic logic [DW+1:0] ref_alu(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                               input bit sub);
        logic [DW:0]   w;
        logic          v;
        w = sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
        if (sub) v = (a[DW-1] != b[DW-1]) && (w[DW-1] != a[DW-1]);
        else     v = (a[DW-1] == b[DW-1]) && (w[DW-1] != a[DW-1]);
        return {w[DW], v, w[DW-1:0]};
    endfunction

    function automatic logic [DW-1:0] enc(input int op, input int adr);
        return DW'((op << 8) | adr);
    endfunction

    task automatic clear_prog();
        for (int i = 0; i < DEPTH; i++) prog[i] = '0;
    endtask

    task automatic run_prog(input string req, input int n_in, input int n_exp,
                            input bit exp_fault, input int stall_max);
        int oi = 0;
        int ii = 0;
        int cyc = 0;
        int st = 0;
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < DEPTH; i++) u_accum_cpu.u_mem.mem[i] = prog[i];
        // R1: reset state seen at the ports
        chk(!stopped && !fault && !in_ready && !out_strobe, "R1 reset status", 
            {stopped, fault, in_ready, out_strobe}, 0);
        chk(!flag_carry && !flag_ovf && out_data == '0, "R1 reset flags/out",
            {flag_carry, flag_ovf, out_data}, 0);
        rst_n = 1'b1;
        while (!stopped && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            if (out_strobe) begin
                if (oi < n_exp) chk(out_data == exp_out[oi], req, out_data, exp_out[oi]);
                else chk(1'b0, {req, " extra output"}, out_data, 0);
                oi++;
            end
            if (in_ready && ii < n_in) begin
                if (st > 0) begin
                    in_valid = 1'b0;
                    st--;
                end else begin
                    in_valid = 1'b1;
                    in_data = ins[ii];
                    ii++;
                    st = (stall_max > 0) ? int'($urandom_range(stall_max, 0)) : 0;
                end
            end else begin
                in_valid = 1'b0;
            end
        end
        chk(stopped == 1'b1, "R10 program stopped", stopped, 1);
        chk(fault == exp_fault, "R11 fault flag", fault, exp_fault);
        chk(oi == n_exp, "R7 output count", oi, n_exp);
        chk(ii == n_in, "R6 inputs consumed", ii, n_in);
        in_valid = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk(stopped && !in_ready && !out_strobe, "R10 quiet after stop",
                {stopped, in_ready, out_strobe}, 4);
        end
        in_valid = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] bad [5];
        logic [DW+1:0] r1;
        logic [DW+1:0] r2;
        logic [DW-1:0] a, x, b, y, z;
        bit            s1, s2;
        void'($urandom(32'd1234));

        // R12 R5 R8 R9 R2: wrap 99->0, store then reload, jump, jump-if-zero, bit 7 ignored
        clear_prog();
        prog[0]  = enc(5, 90);
        prog[1]  = enc(7, 10);
        prog[2]  = enc(6, 98);
        prog[98] = enc(2, 91);
        prog[99] = enc(3, 90);
        prog[90] = 12'd1;
        prog[91] = 12'd1;
        prog[10] = enc(5, 92) | 12'h080;
        prog[11] = 12'h902;
        prog[12] = 12'h000;
        prog[92] = 12'h5A5;
        exp_out[0] = 12'h5A5;
        run_prog("R12 R5 R2 wrap/store/load", 0, 1, 1'b0, 0);

        // R9 R8: conditional jumps on zero, positive, negative
        clear_prog();
        prog[0]  = 12'h901;
        prog[1]  = enc(7, 10);
        prog[2]  = enc(8, 20);
        prog[3]  = 12'h902;
        prog[10] = enc(5, 40);
        prog[11] = 12'h902;
        prog[20] = enc(5, 41);
        prog[21] = 12'h902;
        prog[40] = 12'h111;
        prog[41] = 12'h222;
        begin
            logic [DW-1:0] tin [5] = '{12'h000, 12'h005, 12'h800, 12'hFFF, 12'h7FF};
            logic [DW-1:0] tex [5] = '{12'h111, 12'h222, 12'h800, 12'hFFF, 12'h222};
            for (int t = 0; t < 5; t++) begin
                ins[0] = tin[t];
                exp_out[0] = tex[t];
                run_prog("R9 conditional jump", 1, 1, 1'b0, t);
            end
        end

        // R11: illegal words stop execution after one good output
        bad = '{12'h400, 12'hA00, enc(5, 110), 12'h903, enc(6, 100)};
        for (int t = 0; t < 5; t++) begin
            clear_prog();
            prog[0] = 12'h901;
            prog[1] = 12'h902;
            prog[2] = bad[t];
            prog[3] = 12'h902;
            ins[0] = 12'h123;
            exp_out[0] = 12'h123;
            run_prog("R11 illegal word", 1, 1, 1'b1, 0);
        end

        // R3 R4 R6 R7: directed corners then random operands
        for (int t = 0; t < 30; t++) begin
            a = DW'($urandom); x = DW'($urandom); b = DW'($urandom);
            y = DW'($urandom); z = DW'($urandom);
            s1 = 1'($urandom); s2 = 1'($urandom);
            if (t == 0) begin a = 12'h7FF; x = 12'h001; s1 = 0; b = 12'h000; y = 12'h001; s2 = 1; end
            if (t == 1) begin a = 12'hFFF; x = 12'h001; s1 = 0; b = 12'h800; y = 12'h001; s2 = 1; end
            if (t == 2) begin a = 12'h000; x = 12'h000; s1 = 1; b = 12'h800; y = 12'h800; s2 = 0; end
            clear_prog();
            prog[0] = 12'h901;
            prog[1] = enc(s1 ? 2 : 1, 50);
            prog[2] = 12'h902;
            prog[3] = 12'h901;
            prog[4] = enc(s2 ? 2 : 1, 51);
            prog[5] = 12'h902;
            prog[6] = enc(5, 52);
            prog[7] = 12'h902;
            prog[50] = x; prog[51] = y; prog[52] = z;
            r1 = ref_alu(a, x, s1);
            r2 = ref_alu(b, y, s2);
            ins[0] = a; ins[1] = b;
            exp_out[0] = r1[DW-1:0];
            exp_out[1] = r2[DW-1:0];
            exp_out[2] = z;
            run_prog("R3 arithmetic/load result", 2, 3, 1'b0, 5);
            // R4: flags from the last add/subtract survive the later load
            chk(flag_carry == r2[DW+1], "R4 carry flag", flag_carry, r2[DW+1]);
            chk(flag_ovf == r2[DW], "R4 overflow flag", flag_ovf, r2[DW]);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule